// File: doc/BRIEF.md
# Page Load Write Controller

This block accepts byte writes from a host that drives active-low chip-select, write-strobe and output-enable lines as asynchronous strobes. The strobes and the address and data buses are resampled on a fast system clock. Each qualified write places one byte into a page buffer. The first byte of a load fixes the page. Later bytes must target that same page and may go to any offset inside it. When no new write strobe arrives within a byte-load window, the block starts a self-timed programming interval. At the end of that interval it commits the buffered bytes into a register-based byte array.

While programming runs, the block holds a busy flag high and ignores all strobes. Neighbouring blocks use the busy flag together with the address and data of the most recently accepted byte. Completion polling and write protection are handled by those neighbours. A separate read port gives direct access to the array contents. Window length, programming time and minimum strobe width are parameters counted in system-clock cycles. The default array holds four pages of 256 bytes.

Top module: `plw_page_writer`

## Requirements
- R1: A byte is loaded only if, at the sampled clock edges, chip-select is low, write-strobe is low and output-enable is high together. With output-enable low, write-strobe high or chip-select high, nothing is loaded and the array keeps its contents.
- R2: The address is taken when the write-active condition begins, which is the later of the chip-select and write-strobe falling edges. The data is taken when that condition ends, which is the earlier of their rising edges. Changes on the buses in between are ignored for the address and used for the data.
- R3: A write-active interval shorter than GLITCH_CYC sampled cycles loads nothing. An interval of exactly GLITCH_CYC cycles loads a byte.
- R4: The page number is address bits [ADDR_W-1:OFS_W] and the byte offset is bits [OFS_W-1:0]. The first byte locks the page. Later bytes with the same page number are stored at their own offsets and committed together.
- R5: A later byte whose page number differs from the locked page is dropped, and it does not update the last-byte outputs. It sets page_err, which stays high until reset.
- R6: Programming begins, and busy rises, once LOAD_WIN cycles have elapsed since the start of the most recent write-active interval with no write in progress. A new write started inside the window extends the same load.
- R7: busy stays high for exactly PROG_CYC cycles, and the array does not change during that time. When busy falls, every buffered byte is in the array. Offsets of the page that were not loaded keep their previous value, because there is no erase.
- R8: Write strobes that begin while busy is high are ignored. They change neither the array nor the last-byte outputs.
- R9: last_addr and last_data show the address and data of the most recently accepted byte, and they change only when a byte is accepted.
- R10: After reset, busy and page_err are low, last_addr and last_data are zero, and every array byte reads zero.
- R11: If the same offset is written twice in one load, the later data is what gets committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip-select strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output-enable strobe, active low (writes need it high) |
| addr | input | ADDR_W | Byte address: page number above, offset below |
| din | input | 8 | Write data |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at rd_addr |
| busy | output | 1 | Programming interval in progress |
| page_err | output | 1 | Sticky flag: a byte for a foreign page was dropped |
| last_addr | output | ADDR_W | Address of the last accepted byte |
| last_data | output | 8 | Data of the last accepted byte |

## Verification
The following properties are checked on every cycle:
- the error flag never clears on its own;
- no byte enters the buffer while busy is high;
- the last-byte outputs move only on an accepted byte;
- busy never rises while a write is active;
- every busy interval lasts exactly the programming length;
- the array read port stays stable outside the commit cycle.

Other behaviours need the bench's scenarios to show them. These are which strobe combinations qualify, where the address and data are sampled inside a strobe, the minimum-width boundary, and window extension by a second byte. The same holds for the dropped foreign-page byte and for no-erase behaviour on untouched offsets.

// File: rtl/plw_pkg.sv
// Package: shared state encoding for the page load write controller.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package plw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } plw_state_e;
endpackage

// File: rtl/plw_strobe_sync.sv
// Module: plw_strobe_sync
// Resamples the three strobes together with the address and data buses
// through SYNC_STAGES flops. All of them see the same delay, so a bus value
// seen at a detected edge is the value present when the strobe moved.
// Assumes the host keeps each strobe level for at least one clock period.
module plw_strobe_sync #(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_now,
    output logic              wr_rise,
    output logic              wr_fall,
    output logic [ADDR_W-1:0] addr_s,
    output logic [DATA_W-1:0] din_s
);
    localparam int BUS_W = 3 + ADDR_W + DATA_W;
    localparam logic [BUS_W-1:0] IDLE_BUS = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

    logic [BUS_W-1:0] stage [SYNC_STAGES];
    logic             wr_prev;
    logic             ce_s, we_s, oe_s;

    generate
        for (genvar gs = 0; gs < SYNC_STAGES; gs++) begin : g_stage
            if (gs == 0) begin : g_first
                // First stage: capture the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[0] <= IDLE_BUS;
                    else        stage[0] <= {ce_n, we_n, oe_n, addr, din};
                end
            end else begin : g_next
                // Later stages: shift the sampled bundle along.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[gs] <= IDLE_BUS;
                    else        stage[gs] <= stage[gs-1];
                end
            end
        end
    endgenerate

    // Unpack the last stage.
    always_comb begin
        {ce_s, we_s, oe_s, addr_s, din_s} = stage[SYNC_STAGES-1];
        wr_now = ~ce_s & ~we_s & oe_s;
    end

    // Remember the previous write-active level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_prev <= 1'b0;
        else        wr_prev <= wr_now;
    end

    // Edge flags for the write-active condition.
    always_comb begin
        wr_rise = wr_now & ~wr_prev;
        wr_fall = ~wr_now & wr_prev;
    end
endmodule

// File: rtl/plw_load_ctrl.sv
// Module: plw_load_ctrl
// Qualifies write-active intervals (minimum width and not begun while busy)
// and locks the page. It runs the byte-load window and the programming timer,
// and issues buffer writes and the commit pulse. Expects the edge flags from
// plw_strobe_sync. Requires LOAD_WIN >= 1, PROG_CYC >= 2, GLITCH_CYC >= 1.
module plw_load_ctrl
    import plw_pkg::*;
#(
    parameter int PAGE_NUM_W = 2,
    parameter int OFS_W      = 8,
    parameter int DATA_W     = 8,
    parameter int LOAD_WIN   = 64,
    parameter int PROG_CYC   = 200,
    parameter int GLITCH_CYC = 3,
    localparam int ADDR_W    = PAGE_NUM_W + OFS_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_now,
    input  logic                  wr_rise,
    input  logic                  wr_fall,
    input  logic [ADDR_W-1:0]     addr_s,
    input  logic [DATA_W-1:0]     din_s,
    output logic                  buf_we,
    output logic [OFS_W-1:0]      buf_ofs,
    output logic [DATA_W-1:0]     buf_data,
    output logic                  commit,
    output logic [PAGE_NUM_W-1:0] page_q,
    output logic                  busy,
    output logic                  page_err,
    output logic [ADDR_W-1:0]     last_addr,
    output logic [DATA_W-1:0]     last_data
);
    localparam int WIN_W = $clog2(LOAD_WIN + 1);
    localparam int PRG_W = $clog2(PROG_CYC);
    localparam int LEN_W = $clog2(GLITCH_CYC + 1);

    plw_state_e        state;
    logic [LEN_W-1:0]  len_cnt;
    logic [WIN_W-1:0]  win_cnt;
    logic [PRG_W-1:0]  prog_cnt;
    logic [ADDR_W-1:0] addr_q;
    logic              start_ok;
    logic              accept, page_ok, win_out;

    // Qualification of the write that ends in this cycle.
    always_comb begin
        accept   = wr_fall && start_ok && (len_cnt >= LEN_W'(GLITCH_CYC))
                   && (state != ST_PROG);
        page_ok  = (state == ST_IDLE) || (addr_q[ADDR_W-1:OFS_W] == page_q);
        buf_we   = accept && page_ok;
        buf_ofs  = addr_q[OFS_W-1:0];
        buf_data = din_s;
        win_out  = (win_cnt == WIN_W'(LOAD_WIN)) && !wr_now;
        busy     = (state == ST_PROG);
        commit   = busy && (prog_cnt == PRG_W'(PROG_CYC - 1));
    end

    // Measure the width of the active interval, saturating at the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       len_cnt <= '0;
        else if (wr_rise)                                 len_cnt <= LEN_W'(1);
        else if (wr_now && len_cnt < LEN_W'(GLITCH_CYC))  len_cnt <= len_cnt + 1'b1;
    end

    // Latch the address and busy status at the start of each interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            start_ok <= 1'b0;
        end else if (wr_rise) begin
            addr_q   <= addr_s;
            start_ok <= (state != ST_PROG);
        end
    end

    // Byte-load window: restart at each write start, saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                             win_cnt <= '0;
        else if (wr_rise)                       win_cnt <= '0;
        else if (win_cnt != WIN_W'(LOAD_WIN))   win_cnt <= win_cnt + 1'b1;
    end

    // Load/program sequencing and the programming timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            prog_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: if (buf_we) state <= ST_LOAD;
                ST_LOAD: if (win_out) begin
                    state    <= ST_PROG;
                    prog_cnt <= '0;
                end
                ST_PROG: begin
                    if (commit) state <= ST_IDLE;
                    else        prog_cnt <= prog_cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Page lock, sticky error and the last accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q    <= '0;
            page_err  <= 1'b0;
            last_addr <= '0;
            last_data <= '0;
        end else begin
            if (buf_we && state == ST_IDLE) page_q <= addr_q[ADDR_W-1:OFS_W];
            if (accept && !page_ok)         page_err <= 1'b1;
            if (buf_we) begin
                last_addr <= addr_q;
                last_data <= din_s;
            end
        end
    end

    // Checker counter: length of the current busy interval.
    logic [31:0] chk_busy_len;
    always_ff @(posedge clk) begin
        if (!rst_n)    chk_busy_len <= '0;
        else if (busy) chk_busy_len <= chk_busy_len + 1;
        else           chk_busy_len <= '0;
    end

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        page_err |=> page_err);
    p_no_load_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !buf_we);
    p_last_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_we |=> ($stable(last_addr) && $stable(last_data)));
    p_prog_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wr_now));
    p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (chk_busy_len == PROG_CYC));
endmodule

// File: rtl/plw_page_store.sv
// Module: plw_page_store
// Holds the page buffer with a valid bit per offset and the register-based
// byte array. On the commit pulse, every valid buffered byte is copied into
// the locked page, and the valid bits are then cleared. Expects buf_we and
// commit never to be high together.
module plw_page_store #(
    parameter int PAGE_NUM_W = 2,
    parameter int OFS_W      = 8,
    parameter int DATA_W     = 8,
    localparam int ADDR_W    = PAGE_NUM_W + OFS_W,
    localparam int PAGE_SZ   = 1 << OFS_W,
    localparam int ARR_SZ    = 1 << ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  buf_we,
    input  logic [OFS_W-1:0]      buf_ofs,
    input  logic [DATA_W-1:0]     buf_data,
    input  logic                  commit,
    input  logic [PAGE_NUM_W-1:0] page_q,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_data
);
    logic [DATA_W-1:0]  buf_q [PAGE_SZ];
    logic [PAGE_SZ-1:0] buf_vld;
    logic [DATA_W-1:0]  mem   [ARR_SZ];

    // Page buffer: store loaded bytes and mark their offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_vld <= '0;
            for (int i = 0; i < PAGE_SZ; i++) buf_q[i] <= '0;
        end else if (commit) begin
            buf_vld <= '0;
        end else if (buf_we) begin
            buf_vld[buf_ofs] <= 1'b1;
            buf_q[buf_ofs]   <= buf_data;
        end
    end

    // Array: copy valid buffered bytes into the locked page on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARR_SZ; i++) mem[i] <= '0;
        end else if (commit) begin
            for (int i = 0; i < PAGE_SZ; i++)
                if (buf_vld[i]) mem[{page_q, OFS_W'(i)}] <= buf_q[i];
        end
    end

    // Read port.
    assign rd_data = mem[rd_addr];

    p_array_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> (!$stable(rd_addr) || $stable(rd_data)));
endmodule

// File: rtl/plw_page_writer.sv
// Module: plw_page_writer (top)
// Page load write controller. It resamples the host strobes, qualifies byte
// loads into a page buffer, then runs a self-timed programming interval and
// commits the buffer into the byte array. Assumes the host holds the address
// stable from the write start and the data up to the write end.
module plw_page_writer #(
    parameter int SYNC_STAGES = 2,
    parameter int PAGE_NUM_W  = 2,
    parameter int OFS_W       = 8,
    parameter int LOAD_WIN    = 64,
    parameter int PROG_CYC    = 200,
    parameter int GLITCH_CYC  = 3,
    localparam int ADDR_W     = PAGE_NUM_W + OFS_W,
    localparam int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              page_err,
    output logic [ADDR_W-1:0] last_addr,
    output logic [DATA_W-1:0] last_data
);
    logic                  wr_now, wr_rise, wr_fall;
    logic [ADDR_W-1:0]     addr_s;
    logic [DATA_W-1:0]     din_s;
    logic                  buf_we, commit;
    logic [OFS_W-1:0]      buf_ofs;
    logic [DATA_W-1:0]     buf_data;
    logic [PAGE_NUM_W-1:0] page_q;

    plw_strobe_sync #(
        .SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .wr_now(wr_now), .wr_rise(wr_rise),
        .wr_fall(wr_fall), .addr_s(addr_s), .din_s(din_s)
    );

    plw_load_ctrl #(
        .PAGE_NUM_W(PAGE_NUM_W), .OFS_W(OFS_W), .DATA_W(DATA_W),
        .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC), .GLITCH_CYC(GLITCH_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_now(wr_now), .wr_rise(wr_rise),
        .wr_fall(wr_fall), .addr_s(addr_s), .din_s(din_s),
        .buf_we(buf_we), .buf_ofs(buf_ofs), .buf_data(buf_data),
        .commit(commit), .page_q(page_q), .busy(busy), .page_err(page_err),
        .last_addr(last_addr), .last_data(last_data)
    );

    plw_page_store #(
        .PAGE_NUM_W(PAGE_NUM_W), .OFS_W(OFS_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_ofs(buf_ofs),
        .buf_data(buf_data), .commit(commit), .page_q(page_q),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: tb/plw_page_writer_tb.sv
`timescale 1ns/1ps
module plw_page_writer_tb;
    localparam int LOAD_WIN  = 64;
    localparam int PROG_CYC  = 200;
    localparam int WAIT_DONE = LOAD_WIN + PROG_CYC + 40;
    localparam int NVEC      = 8;
    // Vector: {ce_n, we_n, oe_n, addr[9:0], data[7:0], expect_load}
    localparam logic [21:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b1, 10'h004, 8'hA5, 1'b1},
        {1'b1, 1'b0, 1'b1, 10'h008, 8'h3C, 1'b0},
        {1'b0, 1'b1, 1'b1, 10'h00C, 8'h77, 1'b0},
        {1'b0, 1'b0, 1'b0, 10'h010, 8'h99, 1'b0},
        {1'b0, 1'b0, 1'b1, 10'h314, 8'h5A, 1'b1},
        {1'b1, 1'b1, 1'b0, 10'h020, 8'hEE, 1'b0},
        {1'b0, 1'b0, 1'b1, 10'h1FF, 8'h01, 1'b1},
        {1'b1, 1'b0, 1'b0, 10'h024, 8'h42, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [9:0] addr = '0, rd_addr = '0;
    logic [7:0] din = '0;
    logic [7:0] rd_data, last_data;
    logic [9:0] last_addr;
    logic       busy, page_err;
    logic [7:0] model [1024];
    int         total = 0, bad = 0;

    always #2 clk = ~clk;

    plw_page_writer #(.LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .page_err(page_err), .last_addr(last_addr),
        .last_data(last_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic rdchk(input string tag, input logic [9:0] a);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(tag, rd_data, model[a]);
    endtask

    // Write-strobe controlled byte write with a write-active width of len.
    task automatic wr_byte(input logic [9:0] a, input logic [7:0] d, input int len = 4);
        @(negedge clk); addr = a; din = d; ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk); we_n = 1'b0;
        repeat (len) @(negedge clk);
        we_n = 1'b1;
        repeat (2) @(negedge clk);
        ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(5);
        rst_n = 1'b1;
        idle(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) model[i] = 8'h00;
        do_reset();
        // R10: reset state
        chk("R10 busy", busy, 0);
        chk("R10 page_err", page_err, 0);
        chk("R10 last_addr", last_addr, 0);
        chk("R10 last_data", last_data, 0);
        rdchk("R10 array", 10'h123);

        // R1: strobe combinations from the vector table
        for (int i = 0; i < NVEC; i++) begin
            automatic logic [21:0] v = VEC[i];
            @(negedge clk);
            addr = v[18:9]; din = v[8:1];
            ce_n = v[21]; we_n = v[20]; oe_n = v[19];
            idle(6);
            ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
            idle(4 + WAIT_DONE);
            if (v[0]) model[v[18:9]] = v[8:1];
            rdchk("R1 strobe vector", v[18:9]);
        end

        // R3: a width one short of the minimum loads nothing; the minimum loads
        wr_byte(10'h060, 8'h61, 2);
        idle(LOAD_WIN + 10);
        chk("R3 short pulse no busy", busy, 0);
        rdchk("R3 short pulse ignored", 10'h060);
        wr_byte(10'h061, 8'h62, 3);
        idle(WAIT_DONE);
        model[10'h061] = 8'h62;
        rdchk("R3 minimum pulse loads", 10'h061);

        // R2: address changes after the start and data changes before the end
        @(negedge clk); addr = 10'h040; din = 8'h11; ce_n = 1'b0;
        @(negedge clk); we_n = 1'b0;
        idle(2); addr = 10'h041; din = 8'h22;
        idle(3); we_n = 1'b1;
        @(negedge clk); din = 8'h33;
        idle(2); ce_n = 1'b1;
        idle(WAIT_DONE);
        model[10'h040] = 8'h22;
        rdchk("R2 address at start, data at end", 10'h040);
        rdchk("R2 later address unused", 10'h041);
        // R2: chip-select falling last decides the address, and rising first ends the write
        @(negedge clk); addr = 10'h050; din = 8'h55; we_n = 1'b0;
        idle(2); addr = 10'h051;
        @(negedge clk); ce_n = 1'b0;
        idle(4); ce_n = 1'b1;
        @(negedge clk); din = 8'h66;
        idle(2); we_n = 1'b1;
        idle(WAIT_DONE);
        model[10'h051] = 8'h55;
        rdchk("R2 chip-select controlled address", 10'h051);
        rdchk("R2 early address unused", 10'h050);

        // R4, R7, R9, R11: one page load with a rewrite and an untouched offset
        wr_byte(10'h110, 8'h33);
        idle(WAIT_DONE);
        model[10'h110] = 8'h33;
        wr_byte(10'h100, 8'hB0);
        wr_byte(10'h105, 8'hB5);
        wr_byte(10'h1FF, 8'hBF);
        wr_byte(10'h105, 8'hC5);
        chk("R9 last_addr", last_addr, 10'h105);
        chk("R9 last_data", last_data, 8'hC5);
        idle(LOAD_WIN + 10);
        chk("R6 busy after window", busy, 1);
        rdchk("R7 array unchanged while busy", 10'h100);
        idle(WAIT_DONE);
        chk("R7 busy cleared", busy, 0);
        model[10'h100] = 8'hB0; model[10'h105] = 8'hC5; model[10'h1FF] = 8'hBF;
        rdchk("R4 offset 0", 10'h100);
        rdchk("R11 rewrite wins", 10'h105);
        rdchk("R4 offset 255", 10'h1FF);
        rdchk("R7 no erase of untouched offset", 10'h110);

        // R6: a second byte inside the window extends the load
        wr_byte(10'h200, 8'h20);
        idle(LOAD_WIN - 20);
        chk("R6 busy low inside window", busy, 0);
        wr_byte(10'h201, 8'h21);
        idle(LOAD_WIN - 20);
        chk("R6 window restarted", busy, 0);
        idle(30);
        chk("R6 busy after extended window", busy, 1);
        idle(WAIT_DONE);
        model[10'h200] = 8'h20; model[10'h201] = 8'h21;
        rdchk("R6 first byte", 10'h200);
        rdchk("R6 second byte", 10'h201);

        // R5: foreign page byte dropped and error sticky
        wr_byte(10'h2A0, 8'h44);
        wr_byte(10'h3A0, 8'h55);
        chk("R5 page_err set", page_err, 1);
        chk("R5 R9 last_addr not moved", last_addr, 10'h2A0);
        idle(WAIT_DONE);
        model[10'h2A0] = 8'h44;
        rdchk("R5 locked page byte", 10'h2A0);
        rdchk("R5 foreign byte dropped", 10'h3A0);
        chk("R5 page_err sticky", page_err, 1);

        // R8: strobes during programming are ignored
        wr_byte(10'h030, 8'h31);
        idle(LOAD_WIN + 10);
        chk("R8 busy", busy, 1);
        wr_byte(10'h034, 8'h35);
        chk("R8 last_addr unchanged", last_addr, 10'h030);
        idle(WAIT_DONE);
        model[10'h030] = 8'h31;
        rdchk("R8 byte before busy", 10'h030);
        rdchk("R8 byte during busy ignored", 10'h034);

        // R10: reset clears the sticky error and the array
        do_reset();
        chk("R10 page_err cleared", page_err, 0);
        for (int i = 0; i < 1024; i++) model[i] = 8'h00;
        rdchk("R10 array cleared", 10'h030);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule